// File: doc/BRIEF.md
# Shift-Register Counting Membership Filter

This block answers a cheap membership question for small cache tags before a larger, costlier structure is consulted. Each 5-bit tag is folded into an index of a small counter array. Several tags may share one counter. Inserting a tag steps its counter up. Removing a tag steps its counter down. A probe reports whether the counter is at its zero value. A zero count means the tag is definitely absent. A nonzero count means the tag may be present and the larger set has to be searched.

Each counter is not a binary number. It is the state of a 5-bit maximal-length shift register with feedback polynomial x^5+x^3+1. Counting up is one forward step of that register. Counting down is one inverse step. The zero count is a fixed nonzero seed state. The all-zero pattern is never used. Every operation reads its entry in the cycle it is issued and acts in the next cycle. Updates write back in that second cycle. A later operation that reads the same entry during that write cycle sees the new value, so one operation can be issued every cycle.

Top module: `lfsr_bloom_filter`

## Requirements
- R1: After reset every counter holds the zero count. A probe of any tag then returns not-present, and `rsp_valid` and `rsp_maybe` are low until the first probe response.
- R2: The counter index is tag[2:0] XOR {1'b0, tag[4:3]}. Two tags with the same index share one counter, so an insert of one tag makes a probe of the other report maybe-present.
- R3: `op` is encoded as 2'b00 idle, 2'b01 increment, 2'b10 decrement and 2'b11 probe. A probe issued in cycle T raises `rsp_valid` in cycle T+1 only. In that cycle `rsp_maybe` is 1 exactly when the entry's count is nonzero.
- R4: A decrement undoes an increment. After n increments and then n decrements on one entry (n up to 30), a probe reports not-present.
- R5: A decrement on an entry at the zero count leaves the entry unchanged.
- R6: The count saturates at 30, which is one step before the register sequence returns to the seed. Further increments leave it at 30.
- R7: Operations may be issued back to back. A probe or an update issued in the write cycle of an earlier update to the same entry sees the updated count. No update is lost.
- R8: Probe and idle cycles never change any counter.
- R9: A counter state is never the all-zero pattern. Forward steps use new stage 1 = stage 3 XOR stage 5, and the zero count is the seed 5'b00001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | Operation: 00 idle, 01 increment, 10 decrement, 11 probe |
| tag | input | 5 | Tag that the operation applies to |
| rsp_valid | output | 1 | High in the cycle after a probe |
| rsp_maybe | output | 1 | Probe result: 1 maybe present, 0 definitely absent |

## Verification
The assertions assume that `op` always holds one of its four defined codes. They also assume that `tag` is a known value whenever `op` is not idle, and that `op` is idle while reset is held. The stimulus drives both inputs only from tasks at the falling clock edge. It keeps `op` at idle through reset and between scenarios. It keeps every scenario inside the count range 0 to 30, except for the deliberate extra increments past saturation and decrements below zero. Expected results come from a plain integer count per index that the bench keeps itself.

// File: rtl/lfsr_bloom_filter.sv
module lfsr_bloom_filter #(
  parameter int TAG_W = 5,
  parameter int IDX_W = 3,
  parameter logic [4:0] SEED = 5'b00001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [TAG_W-1:0] tag,
  output logic             rsp_valid,
  output logic             rsp_maybe
);
  localparam int CNT_W = 5;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] OP_IDLE = 2'b00;
  localparam logic [1:0] OP_INC  = 2'b01;
  localparam logic [1:0] OP_DEC  = 2'b10;
  localparam logic [1:0] OP_PRB  = 2'b11;

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] s);
    return {s[3:0], s[2] ^ s[4]};
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] s);
    return {s[0] ^ s[3], s[4:1]};
  endfunction

  function automatic logic [IDX_W-1:0] fold(input logic [TAG_W-1:0] t);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < TAG_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ t[i];
    return h;
  endfunction

  localparam logic [CNT_W-1:0] SAT = step_down(SEED);

  logic [CNT_W-1:0] mem [DEPTH];
  logic             s1_vld;
  logic [1:0]       s1_op;
  logic [IDX_W-1:0] s1_idx;
  logic [CNT_W-1:0] s1_val;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] rd_val;
  logic [IDX_W-1:0] in_idx;
  logic             is_upd;

  assign in_idx = fold(tag);
  assign is_upd = s1_vld && (s1_op == OP_INC || s1_op == OP_DEC);

  always_comb begin
    wr_data = s1_val;
    if (s1_op == OP_INC && s1_val != SAT) wr_data = step_up(s1_val);
    if (s1_op == OP_DEC && s1_val != SEED) wr_data = step_down(s1_val);
  end

  assign rd_val = (is_upd && s1_idx == in_idx) ? wr_data : mem[in_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= SEED;
      s1_vld <= 1'b0;
      s1_op  <= OP_IDLE;
      s1_idx <= '0;
      s1_val <= SEED;
    end else begin
      s1_vld <= (op != OP_IDLE);
      s1_op  <= op;
      s1_idx <= in_idx;
      s1_val <= rd_val;
      if (is_upd) mem[s1_idx] <= wr_data;
    end
  end

  assign rsp_valid = s1_vld && (s1_op == OP_PRB);
  assign rsp_maybe = rsp_valid && (s1_val != SEED);
endmodule

module lfsr_bloom_filter_chk #(
  parameter int TAG_W = 5,
  parameter int IDX_W = 3,
  parameter logic [4:0] SEED = 5'b00001,
  parameter logic [4:0] SAT = 5'b10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       op,
  input logic [IDX_W-1:0] in_idx,
  input logic             rsp_valid,
  input logic             rsp_maybe,
  input logic             s1_vld,
  input logic [1:0]       s1_op,
  input logic [IDX_W-1:0] s1_idx,
  input logic [4:0]       s1_val,
  input logic [4:0]       wr_data,
  input logic             is_upd
);
  // R3
  probe_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b11) |=> rsp_valid);
  // R3
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b11) |=> !rsp_valid);
  // R3
  maybe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_maybe |-> rsp_valid);
  // R9
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_val != 5'b00000 && wr_data != 5'b00000));
  // R5
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_upd && s1_op == 2'b10 && s1_val == SEED) |-> wr_data == SEED);
  // R6
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_upd && s1_op == 2'b01 && s1_val == SAT) |-> wr_data == SAT);
  // R7
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_upd && op != 2'b00 && in_idx == s1_idx) |=> s1_val == $past(wr_data));
endmodule

bind lfsr_bloom_filter lfsr_bloom_filter_chk #(
  .TAG_W(TAG_W), .IDX_W(IDX_W), .SEED(SEED), .SAT(SAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .in_idx(in_idx),
  .rsp_valid(rsp_valid), .rsp_maybe(rsp_maybe),
  .s1_vld(s1_vld), .s1_op(s1_op), .s1_idx(s1_idx), .s1_val(s1_val),
  .wr_data(wr_data), .is_upd(is_upd)
);

// File: tb/lfsr_bloom_filter_test.sv
module lfsr_bloom_filter_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] op = 2'b00;
  logic [4:0] tag = '0;
  logic rsp_valid, rsp_maybe;

  int n_chk = 0;
  int n_fail = 0;
  int cnt [8];
  bit pend_prb = 0;
  bit pend_exp = 0;
  string pend_req = "";

  always #2 clk = ~clk;

  lfsr_bloom_filter uut (.clk(clk), .rst_n(rst_n), .op(op), .tag(tag),
                         .rsp_valid(rsp_valid), .rsp_maybe(rsp_maybe));

  function automatic int hidx(input logic [4:0] t);
    return int'(t[2:0] ^ {1'b0, t[4:3]});
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [4:0] t, input string req);
    @(negedge clk);
    check({pend_req, " rsp_valid"}, rsp_valid, pend_prb);
    if (pend_prb) check({pend_req, " rsp_maybe"}, rsp_maybe, pend_exp);
    pend_prb = (o == 2'b11);
    pend_exp = (cnt[hidx(t)] != 0);
    pend_req = req;
    case (o)
      2'b01: if (cnt[hidx(t)] < 30) cnt[hidx(t)]++;
      2'b10: if (cnt[hidx(t)] > 0) cnt[hidx(t)]--;
      default: ;
    endcase
    op = o;
    tag = t;
  endtask

  task automatic flush(input string req);
    step(2'b00, 5'd0, req);
    step(2'b00, 5'd0, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset rsp_valid", rsp_valid, 1'b0);
    check("R1 reset rsp_maybe", rsp_maybe, 1'b0);
    for (int i = 0; i < 32; i++) step(2'b11, 5'(i), "R1");
    flush("R1");
  endtask

  task automatic t_alias;
    step(2'b01, 5'b00001, "R2");
    step(2'b00, 5'd0, "R2");
    step(2'b11, 5'b01000, "R2 alias");
    step(2'b11, 5'b00010, "R2 other");
    step(2'b11, 5'b00001, "R2 self");
    step(2'b10, 5'b01000, "R2");
    step(2'b11, 5'b00001, "R2 cleared");
    flush("R2");
  endtask

  task automatic t_inc_dec;
    for (int i = 0; i < 5; i++) begin
      step(2'b01, 5'd6, "R4");
      step(2'b00, 5'd0, "R4");
    end
    step(2'b11, 5'd6, "R3 nonzero");
    for (int i = 0; i < 5; i++) begin
      step(2'b10, 5'd6, "R4");
      step(2'b00, 5'd0, "R4");
      step(2'b11, 5'd6, "R4 partial");
    end
    flush("R4");
  endtask

  task automatic t_dec_zero;
    step(2'b10, 5'd3, "R5");
    step(2'b00, 5'd0, "R5");
    step(2'b11, 5'd3, "R5 after floor dec");
    step(2'b01, 5'd3, "R5");
    step(2'b00, 5'd0, "R5");
    step(2'b11, 5'd3, "R5 one");
    step(2'b10, 5'd3, "R5");
    step(2'b00, 5'd0, "R5");
    step(2'b11, 5'd3, "R5 back to zero");
    flush("R5");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 33; i++) step(2'b01, 5'd7, "R6");
    step(2'b11, 5'd7, "R6 saturated");
    for (int i = 0; i < 29; i++) step(2'b10, 5'd7, "R6");
    step(2'b11, 5'd7, "R6 one left");
    step(2'b10, 5'd7, "R6");
    step(2'b11, 5'd7, "R6 empty");
    flush("R6");
  endtask

  task automatic t_b2b;
    step(2'b01, 5'd12, "R7");
    step(2'b11, 5'd12, "R7 probe after inc");
    step(2'b10, 5'd12, "R7");
    step(2'b11, 5'd12, "R7 probe after dec");
    step(2'b01, 5'd13, "R7");
    step(2'b01, 5'd13, "R7");
    step(2'b01, 5'd13, "R7");
    step(2'b10, 5'd13, "R7");
    step(2'b10, 5'd13, "R7");
    step(2'b11, 5'd13, "R7 one left");
    step(2'b10, 5'd13, "R7");
    step(2'b11, 5'd13, "R7 none left");
    flush("R7");
  endtask

  task automatic t_passive;
    step(2'b01, 5'd2, "R8");
    for (int i = 0; i < 4; i++) step(2'b11, 5'd2, "R8 repeated probe");
    for (int i = 0; i < 3; i++) step(2'b00, 5'd2, "R8 idle");
    step(2'b10, 5'd2, "R8");
    step(2'b11, 5'd2, "R8 probes left count at one");
    flush("R8");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_alias;
    t_inc_dec;
    t_dec_zero;
    t_sat;
    t_b2b;
    t_passive;
    // R9: every scenario leaves probes consistent with a never-empty register state
    finish_run;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule